// File: doc/BRIEF.md
# Dual-Clock FIFO Controller for External RAM

This block is the control half of a first-in first-out queue whose storage sits outside it in a dual-port RAM. A producer raises a write request in its own clock domain. A consumer raises a read request in a second clock domain, which may be unrelated to the first. The controller turns each accepted request into a RAM enable plus address. It keeps one pointer per side and reports the queue state to each side in that side's own clock.

Each pointer carries one extra wrap bit. It is passed to the other domain in Gray code through a chain of flip-flops. The full flag, the empty flag, the two threshold flags and the two occupancy counts are all derived from the local pointer and the synchronized remote pointer. Because of this they are conservative: they can lag the true state by the synchronizer delay, but they never claim space or data that does not exist.

Each side gets a one-cycle acknowledge for every accepted access. A request that is refused raises an error pulse in the following cycle instead. The RAM is assumed to return read data one read-clock cycle after its read enable.

Top module: `extram_fifo_ctrl`

## Requirements
- R1: Raising `rst` clears both pointers at once, without waiting for a clock edge. After that, `wrCount` and `rdCount` read 0, `empty` and `almostEmpty` read 1, and `full`, `almostFull`, `wrAck`, `wrOverflow`, `rdValid` and `rdUnderflow` read 0.
- R2: When `wrReq` is high and `full` is low, `memWrEn` is high in that same cycle. `memWrAddr` equals the number of writes accepted since reset, modulo DEPTH. `wrAck` is high in the next write-clock cycle.
- R3: When `wrReq` is high while `full` is high, `memWrEn` stays low and the write pointer does not move. In the next write-clock cycle `wrOverflow` is high and `wrAck` is low.
- R4: When `rdReq` is high and `empty` is low, `memRdEn` is high in that same cycle. `memRdAddr` equals the number of reads accepted since reset, modulo DEPTH. `rdValid` is high in the next read-clock cycle, which is when the RAM data is valid.
- R5: When `rdReq` is high while `empty` is high, `memRdEn` stays low. In the next read-clock cycle `rdUnderflow` is high and `rdValid` is low.
- R6: `full` is high exactly when the write domain sees DEPTH entries held. `empty` is high exactly when the read domain sees no entries.
- R7: `wrCount` is the number of accepted writes minus the number of reads seen through the synchronizer, and `rdCount` is the mirror of that in the read domain. After both clocks have run four cycles with no requests, both counts equal the true occupancy.
- R8: `almostFull` is high when `wrCount >= AFULL_LVL` (default 12). `almostEmpty` is high when `rdCount <= AEMPTY_LVL` (default 2).
- R9: A pointer reaches the other domain only through SYNC_STAGES (default 2) flip-flops. So a write into an empty queue cannot clear `empty` before the second read-clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rst | input | 1 | Asynchronous reset, active high, shared by both domains |
| wrReq | input | 1 | Write request (write domain) |
| rdReq | input | 1 | Read request (read domain) |
| memWrEn | output | 1 | External RAM write enable |
| memWrAddr | output | ADDR_W | External RAM write address |
| memRdEn | output | 1 | External RAM read enable |
| memRdAddr | output | ADDR_W | External RAM read address |
| full | output | 1 | No room, as seen from the write domain |
| almostFull | output | 1 | Write-side count at or above AFULL_LVL |
| wrCount | output | ADDR_W+1 | Occupancy as seen from the write domain |
| wrAck | output | 1 | Previous-cycle write was accepted |
| wrOverflow | output | 1 | Previous-cycle write was refused |
| empty | output | 1 | No data, as seen from the read domain |
| almostEmpty | output | 1 | Read-side count at or below AEMPTY_LVL |
| rdCount | output | ADDR_W+1 | Occupancy as seen from the read domain |
| rdValid | output | 1 | External RAM read data is valid this cycle |
| rdUnderflow | output | 1 | Previous-cycle read was refused |

## Verification
The bench fills the queue past DEPTH and drains it past zero. A full test that is off by one, or that ignores the wrap bit, would either enable a RAM write over unread data or refuse the last free slot, and the overflow and acknowledge pulses would land on the wrong request. The threshold flags are probed on both sides of each limit (11 and 12 entries, 2 and 3 entries), where a strict comparison in place of an inclusive one would flip the flag. A write into an empty queue is followed by an immediate look at `empty`; a design that skipped the synchronizer would drop the flag too early. Reset is also raised between clock edges with data held, so a synchronous-only clear would leave stale counts visible.

// File: rtl/fifo_ctrl_pkg.sv
package fifo_ctrl_pkg;

  // Strobes from the control module to the pointer datapath.
  // wrStep belongs to the write domain, rdStep to the read domain.
  typedef struct packed {
    logic wrStep;
    logic rdStep;
  } ptrStrobe_t;

endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/fifo_ptr_datapath.sv
module fifo_ptr_datapath
  import fifo_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  ptrStrobe_t        strobe,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W:0]   wrCount,
  output logic [ADDR_W:0]   rdCount,
  output logic              fullRaw,
  output logic              emptyRaw
);

  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  logic [PW-1:0] wrBin, wrGray, wrBinNext;
  logic [PW-1:0] rdBin, rdGray, rdBinNext;
  logic [PW-1:0] rdGrayAtWr, wrGrayAtRd;
  logic [PW-1:0] rdBinAtWr, wrBinAtRd;

  assign wrBinNext = wrBin + PW'(strobe.wrStep);
  assign rdBinNext = rdBin + PW'(strobe.rdStep);

  always_ff @(posedge wrClk or posedge rst) begin
    if (rst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= bin2gray(wrBinNext);
    end
  end

  always_ff @(posedge rdClk or posedge rst) begin
    if (rst) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= bin2gray(rdBinNext);
    end
  end

  fifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk(wrClk), .rst(rst), .din(rdGray), .dout(rdGrayAtWr)
  );

  fifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk(rdClk), .rst(rst), .din(wrGray), .dout(wrGrayAtRd)
  );

  assign rdBinAtWr = gray2bin(rdGrayAtWr);
  assign wrBinAtRd = gray2bin(wrGrayAtRd);

  assign memWrAddr = wrBin[ADDR_W-1:0];
  assign memRdAddr = rdBin[ADDR_W-1:0];

  assign wrCount = wrBin - rdBinAtWr;
  assign rdCount = wrBinAtRd - rdBin;

  // Full: the two top Gray bits are inverted and the rest are equal.
  assign fullRaw  = (wrGray == {~rdGrayAtWr[PW-1:PW-2], rdGrayAtWr[PW-3:0]});
  assign emptyRaw = (rdGray == wrGrayAtRd);

endmodule

// File: rtl/fifo_flag_ctrl.sv
module fifo_flag_ctrl
  import fifo_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int AFULL_LVL  = 12,
  parameter int AEMPTY_LVL = 2
) (
  input  logic            wrClk,
  input  logic            rdClk,
  input  logic            rst,
  input  logic            wrReq,
  input  logic            rdReq,
  input  logic            fullRaw,
  input  logic            emptyRaw,
  input  logic [ADDR_W:0] wrCount,
  input  logic [ADDR_W:0] rdCount,
  output ptrStrobe_t      strobe,
  output logic            memWrEn,
  output logic            memRdEn,
  output logic            full,
  output logic            empty,
  output logic            almostFull,
  output logic            almostEmpty,
  output logic            wrAck,
  output logic            wrOverflow,
  output logic            rdValid,
  output logic            rdUnderflow
);

  localparam int CNT_W = ADDR_W + 1;

  logic wrTake, rdTake;

  assign wrTake = wrReq & ~fullRaw;
  assign rdTake = rdReq & ~emptyRaw;

  assign strobe.wrStep = wrTake;
  assign strobe.rdStep = rdTake;
  assign memWrEn       = wrTake;
  assign memRdEn       = rdTake;

  assign full        = fullRaw;
  assign empty       = emptyRaw;
  assign almostFull  = (wrCount >= CNT_W'(AFULL_LVL));
  assign almostEmpty = (rdCount <= CNT_W'(AEMPTY_LVL));

  always_ff @(posedge wrClk or posedge rst) begin
    if (rst) begin
      wrAck      <= 1'b0;
      wrOverflow <= 1'b0;
    end else begin
      wrAck      <= wrTake;
      wrOverflow <= wrReq & fullRaw;
    end
  end

  // The RAM returns data one cycle after memRdEn, so rdValid follows rdTake.
  always_ff @(posedge rdClk or posedge rst) begin
    if (rst) begin
      rdValid     <= 1'b0;
      rdUnderflow <= 1'b0;
    end else begin
      rdValid     <= rdTake;
      rdUnderflow <= rdReq & emptyRaw;
    end
  end

endmodule

// File: rtl/extram_fifo_ctrl.sv
module extram_fifo_ctrl
  import fifo_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int AFULL_LVL   = 12,
  parameter int AEMPTY_LVL  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  logic              wrReq,
  input  logic              rdReq,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              full,
  output logic              almostFull,
  output logic [ADDR_W:0]   wrCount,
  output logic              wrAck,
  output logic              wrOverflow,
  output logic              empty,
  output logic              almostEmpty,
  output logic [ADDR_W:0]   rdCount,
  output logic              rdValid,
  output logic              rdUnderflow
);

  ptrStrobe_t strobe;
  logic       fullRaw, emptyRaw;

  fifo_ptr_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .strobe(strobe),
    .memWrAddr(memWrAddr), .memRdAddr(memRdAddr),
    .wrCount(wrCount), .rdCount(rdCount),
    .fullRaw(fullRaw), .emptyRaw(emptyRaw)
  );

  fifo_flag_ctrl #(.ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL), .AEMPTY_LVL(AEMPTY_LVL)) u_ctl (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst),
    .wrReq(wrReq), .rdReq(rdReq),
    .fullRaw(fullRaw), .emptyRaw(emptyRaw),
    .wrCount(wrCount), .rdCount(rdCount),
    .strobe(strobe), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .full(full), .empty(empty), .almostFull(almostFull), .almostEmpty(almostEmpty),
    .wrAck(wrAck), .wrOverflow(wrOverflow), .rdValid(rdValid), .rdUnderflow(rdUnderflow)
  );

endmodule

// File: rtl/extram_fifo_ctrl_chk.sv
module extram_fifo_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rst,
  input logic              wrReq,
  input logic              rdReq,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              full,
  input logic              almostFull,
  input logic [ADDR_W:0]   wrCount,
  input logic              wrAck,
  input logic              wrOverflow,
  input logic              empty,
  input logic              almostEmpty,
  input logic [ADDR_W:0]   rdCount,
  input logic              rdValid,
  input logic              rdUnderflow
);

  localparam int DEPTH = 1 << ADDR_W;

  AST_WRITE_ACKED: assert property (@(posedge wrClk) disable iff (rst)
    (wrReq && !full) |=> (wrAck && !wrOverflow)); // R2
  AST_WRADDR_STEP: assert property (@(posedge wrClk) disable iff (rst)
    memWrEn |=> (memWrAddr == ADDR_W'($past(memWrAddr) + 1'b1))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (rst)
    (wrReq && full) |=> (wrOverflow && !wrAck)); // R3
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wrClk) disable iff (rst)
    full |-> !memWrEn); // R3
  AST_READ_VALID: assert property (@(posedge rdClk) disable iff (rst)
    memRdEn |=> (rdValid && !rdUnderflow)); // R4
  AST_RDADDR_STEP: assert property (@(posedge rdClk) disable iff (rst)
    memRdEn |=> (memRdAddr == ADDR_W'($past(memRdAddr) + 1'b1))); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (rst)
    (rdReq && empty) |=> (rdUnderflow && !rdValid)); // R5
  AST_WRCOUNT_RANGE: assert property (@(posedge wrClk) disable iff (rst)
    wrCount <= (ADDR_W+1)'(DEPTH)); // R7
  AST_RDCOUNT_RANGE: assert property (@(posedge rdClk) disable iff (rst)
    rdCount <= (ADDR_W+1)'(DEPTH)); // R7
  AST_FULL_IS_ALMOST: assert property (@(posedge wrClk) disable iff (rst)
    full |-> almostFull); // R8
  AST_EMPTY_IS_ALMOST: assert property (@(posedge rdClk) disable iff (rst)
    empty |-> almostEmpty); // R8

endmodule

bind extram_fifo_ctrl extram_fifo_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq),
  .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
  .full(full), .almostFull(almostFull), .wrCount(wrCount), .wrAck(wrAck),
  .wrOverflow(wrOverflow), .empty(empty), .almostEmpty(almostEmpty),
  .rdCount(rdCount), .rdValid(rdValid), .rdUnderflow(rdUnderflow)
);

// File: tb/extram_fifo_ctrl_bench.sv
module extram_fifo_ctrl_bench;

  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int AF     = 12;
  localparam int AE     = 2;

  typedef struct packed {
    logic       isRead;
    logic [5:0] n;
  } step_t;

  // Stimulus table: burst direction and length; expected values come from the model.
  localparam step_t STEPS [9] = '{
    '{1'b0, 6'd3},  '{1'b1, 6'd1},  '{1'b0, 6'd15},
    '{1'b1, 6'd20}, '{1'b0, 6'd12}, '{1'b1, 6'd1},
    '{1'b1, 6'd8},  '{1'b0, 6'd2},  '{1'b1, 6'd6}
  };

  logic wrClk = 1'b0, rdClk = 1'b0, rst = 1'b1;
  logic wrReq = 1'b0, rdReq = 1'b0;
  logic memWrEn, memRdEn, full, almostFull, wrAck, wrOverflow;
  logic empty, almostEmpty, rdValid, rdUnderflow;
  logic [ADDR_W-1:0] memWrAddr, memRdAddr;
  logic [ADDR_W:0]   wrCount, rdCount;

  int checks = 0, fails = 0;
  int occ = 0, wrPtr = 0, rdPtr = 0;
  bit done = 1'b0;

  always #10 wrClk = ~wrClk;
  always #13 rdClk = ~rdClk;

  extram_fifo_ctrl #(.ADDR_W(ADDR_W), .AFULL_LVL(AF), .AEMPTY_LVL(AE)) u_extram_fifo_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .wrReq(wrReq), .rdReq(rdReq),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .full(full), .almostFull(almostFull), .wrCount(wrCount), .wrAck(wrAck),
    .wrOverflow(wrOverflow), .empty(empty), .almostEmpty(almostEmpty),
    .rdCount(rdCount), .rdValid(rdValid), .rdUnderflow(rdUnderflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite();
    bit acc;
    acc = (occ < DEPTH);
    @(negedge wrClk); wrReq = 1'b1; #1;
    chk("R6 full before write", full, occ == DEPTH);
    chk("R8 almostFull", almostFull, occ >= AF);
    chk("R7 wrCount in burst", wrCount, occ);
    chk("R2/R3 memWrEn", memWrEn, acc);
    if (acc) chk("R2 memWrAddr", memWrAddr, wrPtr % DEPTH);
    @(negedge wrClk); wrReq = 1'b0;
    chk("R2/R3 wrAck", wrAck, acc);
    chk("R3 wrOverflow", wrOverflow, !acc);
    if (acc) begin occ++; wrPtr++; end
  endtask

  task automatic doRead();
    bit acc;
    acc = (occ > 0);
    @(negedge rdClk); rdReq = 1'b1; #1;
    chk("R6 empty before read", empty, occ == 0);
    chk("R8 almostEmpty", almostEmpty, occ <= AE);
    chk("R7 rdCount in burst", rdCount, occ);
    chk("R4/R5 memRdEn", memRdEn, acc);
    if (acc) chk("R4 memRdAddr", memRdAddr, rdPtr % DEPTH);
    @(negedge rdClk); rdReq = 1'b0;
    chk("R4/R5 rdValid", rdValid, acc);
    chk("R5 rdUnderflow", rdUnderflow, !acc);
    if (acc) begin occ--; rdPtr++; end
  endtask

  task automatic settle();
    repeat (4) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
    chk("R7 wrCount settled", wrCount, occ);
    chk("R6 full settled", full, occ == DEPTH);
    chk("R8 almostFull settled", almostFull, occ >= AF);
    chk("R3 wrOverflow one pulse", wrOverflow, 0);
    @(negedge rdClk);
    chk("R7 rdCount settled", rdCount, occ);
    chk("R6 empty settled", empty, occ == 0);
    chk("R8 almostEmpty settled", almostEmpty, occ <= AE);
    chk("R5 rdUnderflow one pulse", rdUnderflow, 0);
  endtask

  task automatic checkResetState();
    chk("R1 wrCount", wrCount, 0);
    chk("R1 rdCount", rdCount, 0);
    chk("R1 empty", empty, 1);
    chk("R1 almostEmpty", almostEmpty, 1);
    chk("R1 full", full, 0);
    chk("R1 almostFull", almostFull, 0);
    chk("R1 wrAck", wrAck, 0);
    chk("R1 wrOverflow", wrOverflow, 0);
    chk("R1 rdValid", rdValid, 0);
    chk("R1 rdUnderflow", rdUnderflow, 0);
  endtask

  initial begin
    #57;
    checkResetState();
    rst = 1'b0;
    settle();

    foreach (STEPS[i]) begin
      for (int k = 0; k < int'(STEPS[i].n); k++) begin
        if (STEPS[i].isRead) doRead();
        else doWrite();
      end
      settle();
    end

    // R9: a fresh write into an empty queue must not clear empty right away.
    chk("R9 empty before write", empty, 1);
    @(negedge wrClk); wrReq = 1'b1;
    @(negedge wrClk); wrReq = 1'b0;
    chk("R9 empty still set after write edge", empty, 1);
    occ++; wrPtr++;
    repeat (3) @(negedge rdClk);
    chk("R9 empty cleared after sync", empty, 0);
    chk("R9 rdCount after sync", rdCount, 1);

    // R1: asynchronous clear while data is held, between clock edges.
    for (int k = 0; k < 4; k++) doWrite();
    settle();
    #7 rst = 1'b1;
    #2;
    checkResetState();
    occ = 0; wrPtr = 0; rdPtr = 0;
    @(negedge wrClk); rst = 1'b0;
    settle();
    doWrite();
    settle();
    doRead();
    settle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule